// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Permission Check

This block caches address translations for a processor's memory unit. Each slot pairs a virtual page number tag with a complete page table entry. The entry holds a present bit, read, write and execute permission bits and the physical frame number. A lookup carries a virtual address and an access kind. All tags are compared in parallel. One clock edge later the block reports exactly one outcome: a permitted hit with the physical address, a miss, or a permission fault.

After a miss, the walker outside the block writes the entry it found through the fill port. The block picks the slot. A single page can be dropped when its protection changes. On a context switch, a flush empties every slot. Page walks and fault handling are done outside the block.

Top module: `xlate_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high at a rising edge produces `rsp_valid` high after that edge. Exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is then set. With no lookup, `rsp_valid` is low. After reset, `rsp_valid` is low and every slot is empty.
- R2: A lookup whose page number (address bits above the low `PAGE_W` bits) equals the tag of an occupied slot is a hit. When permitted, `rsp_pa` is that slot's frame number placed above the unchanged low `PAGE_W` address bits.
- R3: The access kind on `lk_op` is encoded as 00 read, 01 write and 10 execute. Code 11 is reserved and always faults. A matching slot whose present bit is clear, or whose permission bit for the requested kind is clear, gives `rsp_fault` with `rsp_pa` zero.
- R4: A lookup that matches no occupied slot gives `rsp_miss` with `rsp_pa` zero.
- R5: A fill whose page number is not cached goes into the lowest-numbered empty slot when one exists.
- R6: A fill into a full cache evicts the slot named by a rotating pointer. The pointer is 0 after reset and advances by one, wrapping after the last slot, on each such eviction.
- R7: A fill whose page number is already cached overwrites that slot and creates no second copy.
- R8: An invalidate empties only the slot that holds the given page number. Other slots are kept.
- R9: A flush empties every slot, so later lookups miss.
- R10: When flush and fill arrive in the same cycle, the flush acts first. Afterwards only the filled page is cached.
- R11: A permitted write hit sets `rsp_dirty` with the response. Read and execute hits, and all misses and faults, leave it low.
- R12: A lookup in the same cycle as a fill, invalidate or flush sees the cache contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_op | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| fill_en | input | 1 | Write an entry |
| fill_vpn | input | VA_W-PAGE_W | Page number of the entry |
| fill_pfn | input | PA_W-PAGE_W | Frame number of the entry |
| fill_present | input | 1 | Entry present bit |
| fill_rd | input | 1 | Entry read permission |
| fill_wr | input | 1 | Entry write permission |
| fill_ex | input | 1 | Entry execute permission |
| inv_en | input | 1 | Drop one page |
| inv_vpn | input | VA_W-PAGE_W | Page number to drop |
| flush | input | 1 | Empty all slots |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | No slot matched |
| rsp_fault | output | 1 | Matched but access denied or entry not present |
| rsp_pa | output | PA_W | Physical address on a permitted hit, else zero |
| rsp_dirty | output | 1 | Permitted write hit: the page becomes dirty |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a lookup and a cache update. The bench raises a lookup in the same cycle as a fill that evicts the looked-up page, and in the same cycle as a flush. It expects the pre-update result, then checks on the next lookups that the update took effect.

The second pair is flush and fill together. Afterwards the bench expects the filled page to hit and a page cached before the flush to miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_EXEC  = 2'b10,
        OP_RSVD  = 2'b11
    } acc_op_e;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_FAULT = 2'd2
    } result_e;

    typedef struct packed {
        logic present;
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    function automatic logic op_allowed(perm_t p, acc_op_e op);
        logic ok;
        case (op)
            OP_READ:  ok = p.rd;
            OP_WRITE: ok = p.wr;
            OP_EXEC:  ok = p.ex;
            default:  ok = 1'b0;
        endcase
        return ok & p.present;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 16,
    parameter int KEY_W = 20
) (
    input  logic [N-1:0]            used,
    input  logic [N-1:0][KEY_W-1:0] tags,
    input  logic [KEY_W-1:0]        key,
    output logic [N-1:0]            match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = used[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlb_check.sv
module tlb_check
    import tlb_pkg::*;
#(
    parameter int N      = 16,
    parameter int PFN_W  = 20,
    parameter int PAGE_W = 12
) (
    input  logic [N-1:0]            match,
    input  perm_t [N-1:0]           perms,
    input  logic [N-1:0][PFN_W-1:0] pfns,
    input  acc_op_e                 op,
    input  logic [PAGE_W-1:0]       offset,
    output result_e                 result,
    output logic [PFN_W+PAGE_W-1:0] pa,
    output logic                    dirty
);
    perm_t             sel_perm;
    logic [PFN_W-1:0]  sel_pfn;

    always_comb begin
        sel_perm = '0;
        sel_pfn  = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                sel_perm = perm_t'(sel_perm | perms[i]);
                sel_pfn  = sel_pfn | pfns[i];
            end
        end
    end

    always_comb begin
        if (match == '0)                     result = RES_MISS;
        else if (!op_allowed(sel_perm, op))  result = RES_FAULT;
        else                                 result = RES_HIT;
        pa    = (result == RES_HIT) ? {sel_pfn, offset} : '0;
        dirty = (result == RES_HIT) && (op == OP_WRITE);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     used,
    input  logic [N-1:0]     fill_match,
    input  logic             flush,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output logic             evict
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] hit_idx;

    always_comb begin
        free_idx = '0;
        hit_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i])      free_idx = IDX_W'(i);
            if (fill_match[i]) hit_idx  = IDX_W'(i);
        end
    end

    always_comb begin
        evict = 1'b0;
        if (flush)                  slot = '0;
        else if (fill_match != '0)  slot = hit_idx;
        else if (!(&used))          slot = free_idx;
        else begin
            slot  = rr_ptr;
            evict = 1'b1;
        end
    end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PAGE_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    input  logic [VA_W-1:0]      lk_va,
    input  logic [1:0]           lk_op,
    input  logic                 fill_en,
    input  logic [VA_W-PAGE_W-1:0] fill_vpn,
    input  logic [PA_W-PAGE_W-1:0] fill_pfn,
    input  logic                 fill_present,
    input  logic                 fill_rd,
    input  logic                 fill_wr,
    input  logic                 fill_ex,
    input  logic                 inv_en,
    input  logic [VA_W-PAGE_W-1:0] inv_vpn,
    input  logic                 flush,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic                 rsp_fault,
    output logic [PA_W-1:0]      rsp_pa,
    output logic                 rsp_dirty
);
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PFN_W = PA_W - PAGE_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            used_q, used_d;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    perm_t [ENTRIES-1:0]           perm_q;
    logic [IDX_W-1:0]              rr_q;

    logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
    logic [IDX_W-1:0]   fill_slot;
    logic               fill_evict;
    result_e            lk_result;
    logic [PA_W-1:0]    lk_pa;
    logic               lk_dirty;

    tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_lk (
        .used(used_q), .tags(tag_q), .key(lk_va[VA_W-1:PAGE_W]), .match(lk_match));
    tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_fill (
        .used(used_q), .tags(tag_q), .key(fill_vpn), .match(fill_match));
    tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_inv (
        .used(used_q), .tags(tag_q), .key(inv_vpn), .match(inv_match));

    tlb_check #(.N(ENTRIES), .PFN_W(PFN_W), .PAGE_W(PAGE_W)) u_check (
        .match(lk_match), .perms(perm_q), .pfns(pfn_q), .op(acc_op_e'(lk_op)),
        .offset(lk_va[PAGE_W-1:0]), .result(lk_result), .pa(lk_pa), .dirty(lk_dirty));

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .used(used_q), .fill_match(fill_match), .flush(flush), .rr_ptr(rr_q),
        .slot(fill_slot), .evict(fill_evict));

    // update order: flush, then invalidate, then fill
    always_comb begin
        used_d = used_q;
        if (flush)   used_d = '0;
        if (inv_en)  used_d = used_d & ~inv_match;
        if (fill_en) used_d[fill_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q    <= '0;
            rr_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
            rsp_dirty <= 1'b0;
        end else begin
            used_q    <= used_d;
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (lk_result == RES_HIT);
            rsp_miss  <= lk_valid && (lk_result == RES_MISS);
            rsp_fault <= lk_valid && (lk_result == RES_FAULT);
            rsp_pa    <= lk_valid ? lk_pa : '0;
            rsp_dirty <= lk_valid && lk_dirty;
            if (fill_en && fill_evict)
                rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_slot]  <= fill_vpn;
            pfn_q[fill_slot]  <= fill_pfn;
            perm_q[fill_slot] <= '{present: fill_present, rd: fill_rd,
                                   wr: fill_wr, ex: fill_ex};
        end
    end

    p_one_outcome_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
    p_resp_next_r1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    p_no_dup_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (flush && !fill_en) |=> (used_q == '0));
    p_flush_fill_r10: assert property (@(posedge clk) disable iff (rst)
        (flush && fill_en) |=> ($countones(used_q) == 1));
    p_dirty_hit_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_dirty |-> rsp_hit);
    p_evict_full_r6: assert property (@(posedge clk) disable iff (rst)
        (fill_en && fill_evict) |-> (&used_q));
endmodule

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 32, PA_W = 32, PAGE_W = 12;
    localparam int VPN_W = VA_W - PAGE_W, PFN_W = PA_W - PAGE_W;

    typedef struct {
        int              res;   // 0 miss, 1 hit, 2 fault
        logic [PA_W-1:0] pa;
        logic            dirty;
        string           tag;
    } exp_t;

    logic clk = 0, rst = 1;
    logic lk_valid = 0; logic [VA_W-1:0] lk_va = '0; logic [1:0] lk_op = '0;
    logic fill_en = 0; logic [VPN_W-1:0] fill_vpn = '0; logic [PFN_W-1:0] fill_pfn = '0;
    logic fill_present = 0, fill_rd = 0, fill_wr = 0, fill_ex = 0;
    logic inv_en = 0; logic [VPN_W-1:0] inv_vpn = '0; logic flush = 0;
    logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [PA_W-1:0] rsp_pa;

    int compared = 0, mismatched = 0;
    bit finished = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_cache uut (.*);

    task automatic clear_in();
        lk_valid = 0; fill_en = 0; inv_en = 0; flush = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_in();
    endtask

    task automatic arm_look(input logic [VA_W-1:0] va, input logic [1:0] op,
                            input int res, input logic [PA_W-1:0] pa,
                            input logic dirty, input string tag);
        exp_t e;
        lk_valid = 1; lk_va = va; lk_op = op;
        e.res = res; e.pa = pa; e.dirty = dirty; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic look(input logic [VA_W-1:0] va, input logic [1:0] op,
                        input int res, input logic [PA_W-1:0] pa,
                        input logic dirty, input string tag);
        arm_look(va, op, res, pa, dirty, tag);
        tick();
    endtask

    task automatic arm_fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                            input logic [3:0] prwx);
        fill_en = 1; fill_vpn = vpn; fill_pfn = pfn;
        {fill_present, fill_rd, fill_wr, fill_ex} = prwx;
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                        input logic [3:0] prwx);
        arm_fill(vpn, pfn, prwx);
        tick();
    endtask

    function automatic logic [VA_W-1:0] va_of(int vpn, int off);
        return VA_W'((vpn << PAGE_W) | off);
    endfunction

    function automatic logic [PA_W-1:0] pa_of(int pfn, int off);
        return PA_W'((pfn << PAGE_W) | off);
    endfunction

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            int got;
            exp_t e;
            got = rsp_hit ? 1 : rsp_fault ? 2 : rsp_miss ? 0 : 3;
            compared++;
            if (sb.size() == 0) begin
                mismatched++;
                $display("FAIL R1 unexpected response: got %0d expected none", got);
            end else begin
                e = sb.pop_front();
                if (got != e.res || rsp_pa != e.pa || rsp_dirty != e.dirty) begin
                    mismatched++;
                    $display("FAIL %s: got res=%0d pa=%h dirty=%0b expected res=%0d pa=%h dirty=%0b",
                             e.tag, got, rsp_pa, rsp_dirty, e.res, e.pa, e.dirty);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        compared++;
        if (rsp_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 reset: got rsp_valid=%b expected 0", rsp_valid);
        end
        look(va_of(5, 'h123), 2'b00, 0, '0, 0, "R4 miss on empty");
        fill(20'd5, 20'hABCDE, 4'b1110);
        look(va_of(5, 'h123), 2'b00, 1, 32'hABCDE123, 0, "R2 read hit pa");
        look(va_of(5, 'h123), 2'b01, 1, 32'hABCDE123, 1, "R11 write hit dirty");
        look(va_of(5, 'h123), 2'b10, 2, '0, 0, "R3 exec denied");
        look(va_of(5, 'h123), 2'b11, 2, '0, 0, "R3 reserved op");
        fill(20'd6, 20'h11111, 4'b0111);
        look(va_of(6, 'h0), 2'b00, 2, '0, 0, "R3 not present");
        fill(20'd5, 20'h22222, 4'b1100);
        look(va_of(5, 'h123), 2'b00, 1, 32'h22222123, 0, "R7 refill overwrites");
        look(va_of(5, 'h123), 2'b01, 2, '0, 0, "R7 refill perms");
        inv_en = 1; inv_vpn = 20'd6; tick();
        look(va_of(6, 'h0), 2'b00, 0, '0, 0, "R8 invalidated page");
        look(va_of(5, 'h1), 2'b00, 1, 32'h22222001, 0, "R8 other page kept");
        // slot0=5, slot1 free -> vpn7 must land in slot1 (R5)
        fill(20'd7, 20'h107, 4'b1111);
        for (int v = 8; v <= 21; v++) fill(VPN_W'(v), PFN_W'(v + 'h100), 4'b1111);
        look(va_of(21, 'h10), 2'b10, 1, pa_of('h115, 'h10), 0, "R5 last slot filled");
        fill(20'd30, 20'h11E, 4'b1111);     // evicts slot0 (vpn5)
        look(va_of(5, 'h0), 2'b00, 0, '0, 0, "R6 first eviction slot0");
        look(va_of(30, 'h7), 2'b00, 1, pa_of('h11E, 'h7), 0, "R6 new page hit");
        fill(20'd31, 20'h11F, 4'b1111);     // evicts slot1 (vpn7)
        look(va_of(7, 'h0), 2'b00, 0, '0, 0, "R5 vpn7 was in slot1 / R6 pointer advanced");
        look(va_of(9, 'h0), 2'b00, 1, pa_of('h109, 0), 0, "R6 unrelated page kept");
        // R12: fill evicting slot2 (vpn8) while looking up vpn8
        arm_fill(20'd40, 20'h128, 4'b1111);
        arm_look(va_of(8, 'h456), 2'b00, 1, pa_of('h108, 'h456), 0, "R12 lookup sees pre-fill");
        tick();
        look(va_of(8, 'h456), 2'b00, 0, '0, 0, "R6 third eviction slot2");
        look(va_of(40, 'h456), 2'b01, 1, pa_of('h128, 'h456), 1, "R6 evicting fill hit");
        flush = 1; tick();
        look(va_of(30, 'h0), 2'b00, 0, '0, 0, "R9 flush empties");
        look(va_of(40, 'h0), 2'b00, 0, '0, 0, "R9 flush empties all");
        fill(20'd50, 20'h150, 4'b1111);
        flush = 1;
        arm_fill(20'd60, 20'h160, 4'b1111);
        arm_look(va_of(50, 'h8), 2'b00, 1, pa_of('h150, 'h8), 0, "R12 lookup sees pre-flush");
        tick();
        look(va_of(50, 'h8), 2'b00, 0, '0, 0, "R10 flush before fill");
        look(va_of(60, 'h8), 2'b10, 1, pa_of('h160, 'h8), 0, "R10 fill survives flush");
        repeat (3) @(negedge clk);
        compared++;
        if (sb.size() != 0) begin
            mismatched++;
            $display("FAIL R1 missing responses: got %0d pending expected 0", sb.size());
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule